// File: doc/BRIEF.md
# UART Transmit Queue with Interrupt Sources

This block sits in front of a UART bit serializer. Software pushes data words into a small first-in first-out queue. The queue hands the oldest word to the serializer over a valid/ready handshake, but only while transmission is enabled. Two status bits tell software when it may write and when all queued traffic has left the line. A clear strobe discards everything that is queued.

Four interrupt lines come out of the block:
- a level interrupt when the queue occupancy has fallen to a programmed count;
- a sticky error when a write arrives while the queue is full;
- an idle interrupt when nothing is queued and the shifter has finished;
- a sticky notice that the active-low clear-to-send input has toggled. That input is asynchronous and is resynchronised before edge detection.

Top module: `uart_tx_queue`

## Requirements
- R1: Words leave through `out_data` in the order they were accepted. `out_valid` is high while a word is queued and transmission is enabled. A word is removed in a cycle where both `out_valid` and `out_ready` are high.
- R2: `st_ready` is high exactly when the queue holds fewer than DEPTH words.
- R3: A write while the queue is full is dropped and leaves the queued words unchanged. It sets `irq_ovf`, which stays high until a cycle with `ovf_clr` high (a new overflow in that cycle wins).
- R4: `irq_level` is high whenever the queue occupancy is less than or equal to `level_cnt`.
- R5: `irq_idle` is high only when the queue is empty and `shift_busy` is low.
- R6: `st_busy` is high while the queue holds a word or `shift_busy` is high. It stays high until the last word has been shifted out.
- R7: `q_clear` empties the queue and clears `irq_ovf`. A write in the same cycle is discarded.
- R8: Any change of `cts_n` passes through two synchronising flops. It sets the sticky `irq_cts` at the third rising edge after the change, and `cts_ack` clears it.
- R9: With `tx_en` low no word is offered (`out_valid` low), but writes are still accepted into the queue.
- R10: After reset the queue is empty: `st_ready`=1, `out_valid`=0, `st_busy`=0, `irq_idle`=1, `irq_ovf`=0, `irq_cts`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | DW | Word to queue |
| level_cnt | input | AW+1 | Occupancy threshold for `irq_level` |
| tx_en | input | 1 | Transmit enable |
| q_clear | input | 1 | Discard all queued words |
| ovf_clr | input | 1 | Write-one-to-clear for `irq_ovf` |
| cts_ack | input | 1 | Write-one-to-clear for `irq_cts` |
| cts_n | input | 1 | Asynchronous active-low clear-to-send |
| shift_busy | input | 1 | Serializer is shifting a word |
| out_valid | output | 1 | Head word available to serializer |
| out_data | output | DW | Head word |
| out_ready | input | 1 | Serializer takes the head word |
| st_ready | output | 1 | Queue can accept a write |
| st_busy | output | 1 | Data still queued or shifting |
| irq_level | output | 1 | Occupancy at or below threshold |
| irq_ovf | output | 1 | Sticky overflow error |
| irq_idle | output | 1 | Queue empty and shifter idle |
| irq_cts | output | 1 | Sticky clear-to-send change |

## Verification
The bench fills the queue to the brim and writes once more. A design that let the extra word overwrite a slot or move a pointer would reorder the drained words or show the wrong fill.

It also does the following:
- Pops and pushes in the same cycle at a partial fill. A miscounting design shifts the threshold and ready indications.
- Holds the shifter busy with an empty queue. This exposes an idle interrupt that only looks at the queue.
- Steps the clear-to-send input and checks the exact edge where the change appears. A missing synchroniser stage or a detector for one edge direction fails there.
- Pairs a clear with a write, to catch a write that survives the clear.

// File: rtl/uart_tx_queue.sv
module uart_tx_queue #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [DW-1:0]                wr_data,
  input  logic [$clog2(DEPTH):0]       level_cnt,
  input  logic                         tx_en,
  input  logic                         q_clear,
  input  logic                         ovf_clr,
  input  logic                         cts_ack,
  input  logic                         cts_n,
  input  logic                         shift_busy,
  output logic                         out_valid,
  output logic [DW-1:0]                out_data,
  input  logic                         out_ready,
  output logic                         st_ready,
  output logic                         st_busy,
  output logic                         irq_level,
  output logic                         irq_ovf,
  output logic                         irq_idle,
  output logic                         irq_cts
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] fill;
  logic          cts_s1, cts_s2, cts_q;

  wire full  = (fill == CW'(DEPTH));
  wire empty = (fill == '0);
  wire pop   = out_valid && out_ready;
  wire push  = wr_en && !full;
  wire cts_edge = cts_s2 ^ cts_q;

  assign out_valid = tx_en && !empty;
  assign out_data  = mem[rptr];
  assign st_ready  = !full;
  assign st_busy   = !empty || shift_busy;
  assign irq_level = (fill <= level_cnt);
  assign irq_idle  = empty && !shift_busy;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else if (q_clear) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      fill <= fill + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !q_clear) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_ovf <= 1'b0;
    else if (q_clear) irq_ovf <= 1'b0;
    else              irq_ovf <= (irq_ovf && !ovf_clr) || (wr_en && full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_s1  <= 1'b1;
      cts_s2  <= 1'b1;
      cts_q   <= 1'b1;
      irq_cts <= 1'b0;
    end else begin
      cts_s1  <= cts_n;
      cts_s2  <= cts_s1;
      cts_q   <= cts_s2;
      irq_cts <= (irq_cts && !cts_ack) || cts_edge;
    end
  end

  // R1
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && tx_en && !q_clear |=> out_valid && $stable(out_data));

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_ready && !pop && !q_clear |=> !st_ready && $stable(fill));

  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf && !ovf_clr && !q_clear |=> irq_ovf);

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_idle |-> !out_valid && !st_busy);

  // R7
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_clear |=> !out_valid && !irq_ovf && st_ready && !st_busy || shift_busy);

  // R9
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en && !wr_en && !q_clear |=> $stable(fill));

  // R8
  cts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cts && !cts_ack |=> irq_cts);
endmodule

// File: tb/tb_uart_tx_queue.sv
module tb_uart_tx_queue;
  localparam int DW = 8;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, tx_en = 1, q_clear = 0, ovf_clr = 0, cts_ack = 0;
  logic cts_n = 1, shift_busy = 0, out_ready = 0;
  logic [DW-1:0] wr_data = '0;
  logic [2:0] level_cnt = 3'd1;
  logic out_valid, st_ready, st_busy, irq_level, irq_ovf, irq_idle, irq_cts;
  logic [DW-1:0] out_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_tx_queue #(.DW(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .level_cnt(level_cnt), .tx_en(tx_en), .q_clear(q_clear),
    .ovf_clr(ovf_clr), .cts_ack(cts_ack), .cts_n(cts_n),
    .shift_busy(shift_busy), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .st_ready(st_ready), .st_busy(st_busy),
    .irq_level(irq_level), .irq_ovf(irq_ovf), .irq_idle(irq_idle),
    .irq_cts(irq_cts)
  );

  // {wr, wdata, take, exp_valid, exp_data, exp_level, exp_idle, exp_ready}
  localparam logic [21:0] VEC [0:8] = '{
    {1'b1, 8'hA1, 1'b0, 1'b1, 8'hA1, 1'b1, 1'b0, 1'b1},
    {1'b1, 8'hB2, 1'b0, 1'b1, 8'hA1, 1'b0, 1'b0, 1'b1},
    {1'b1, 8'hC3, 1'b0, 1'b1, 8'hA1, 1'b0, 1'b0, 1'b1},
    {1'b1, 8'hD4, 1'b0, 1'b1, 8'hA1, 1'b0, 1'b0, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b1, 8'hB2, 1'b0, 1'b0, 1'b1},
    {1'b1, 8'hE5, 1'b1, 1'b1, 8'hC3, 1'b0, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b1, 1'b1, 8'hD4, 1'b0, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b1, 1'b1, 8'hE5, 1'b1, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input logic [DW-1:0] d);
    wr_en = 1; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 ready", st_ready, 1);
    check("R10 valid", out_valid, 0);
    check("R10 busy", st_busy, 0);
    check("R10 idle", irq_idle, 1);
    check("R10 ovf", irq_ovf, 0);
    check("R10 cts", irq_cts, 0);
    rst_n = 1;
    step();

    // R1 R2 R4 R5 table walk
    for (int i = 0; i < 9; i++) begin
      wr_en = VEC[i][21];
      wr_data = VEC[i][20:13];
      out_ready = VEC[i][12];
      step();
      wr_en = 0;
      out_ready = 0;
      check("R1 valid", out_valid, VEC[i][11]);
      if (VEC[i][11]) check("R1 data", out_data, VEC[i][10:3]);
      check("R4 level", irq_level, VEC[i][2]);
      check("R5 idle", irq_idle, VEC[i][1]);
      check("R2 ready", st_ready, VEC[i][0]);
    end

    // R4 with a different threshold
    level_cnt = 3'd3;
    put(8'h11); put(8'h22); put(8'h33);
    check("R4 at threshold", irq_level, 1);
    put(8'h44);
    check("R4 above threshold", irq_level, 0);
    check("R2 full", st_ready, 0);

    // R3 overflow keeps contents
    put(8'hEE);
    check("R3 ovf set", irq_ovf, 1);
    check("R3 still full", st_ready, 0);
    step();
    check("R3 sticky", irq_ovf, 1);
    for (int k = 0; k < 4; k++) begin
      check("R3 order", out_data, 8'h11 * (k + 1));
      out_ready = 1;
      step();
      out_ready = 0;
    end
    check("R3 drained", out_valid, 0);
    ovf_clr = 1;
    step();
    ovf_clr = 0;
    check("R3 cleared", irq_ovf, 0);

    // R9 enable gate
    tx_en = 0;
    out_ready = 1;
    put(8'h5A);
    put(8'h6B);
    check("R9 no offer", out_valid, 0);
    check("R6 busy with data", st_busy, 1);
    out_ready = 0;
    tx_en = 1;
    #1;
    check("R9 head kept", out_data, 8'h5A);
    check("R9 offered", out_valid, 1);

    // R7 clear with simultaneous write, after overflow
    put(8'h01); put(8'h02);
    put(8'h03);
    check("R3 ovf again", irq_ovf, 1);
    q_clear = 1; wr_en = 1; wr_data = 8'h77;
    step();
    q_clear = 0; wr_en = 0;
    check("R7 empty", out_valid, 0);
    check("R7 ovf clr", irq_ovf, 0);
    check("R7 ready", st_ready, 1);

    // R5 R6 shifter busy
    shift_busy = 1;
    step();
    check("R5 idle held off", irq_idle, 0);
    check("R6 busy from shifter", st_busy, 1);
    shift_busy = 0;
    #1;
    check("R5 idle", irq_idle, 1);
    check("R6 not busy", st_busy, 0);

    // R8 clear-to-send change timing
    cts_n = 0;
    step(); step();
    check("R8 not yet", irq_cts, 0);
    step();
    check("R8 set", irq_cts, 1);
    step();
    check("R8 sticky", irq_cts, 1);
    cts_ack = 1;
    step();
    cts_ack = 0;
    check("R8 cleared", irq_cts, 0);
    cts_n = 1;
    step(); step(); step();
    check("R8 rising change", irq_cts, 1);

    summary();
  end
endmodule